// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block sits behind a set of four address/data comparators in an on-chip debug unit. Each comparator sends the block a single-cycle match pulse. After software arms the block, it walks through three working states (State1, State2, State3). It moves on when a selected comparator channel fires. When it reaches the Final state it emits a one-cycle trigger pulse, drops back to idle and ends the debug session.

In State1 and State2, a small per-state code picks one channel and the state that channel leads to. In State3, a 4-bit code picks from a fixed set of routes, several of which name two channels. When matches arrive in the same cycle, a route to Final beats every other route. Among the remaining routes, the lowest-numbered channel wins.

During a session the block also keeps one sticky flag per channel. Each flag records whether that channel ever matched. The flags survive the end of the session so software can inspect them afterwards. Only a new arm clears them. Software reads the flags through a byte-wide read port, which shows them only when a 2-bit bank select holds 11.

Top module: `dbg_seq_top`

## Requirements
- R1: While reset is held and after it is released, `state_o` reads 00 (idle), `armed_o` and `trig_o` are low, and `rd_data` reads 0x00 for every bank select.
- R2: A cycle with `arm_wr` high clears all four flags and puts `state_o` at 01 (State1) from the next cycle, with `trig_o` low. This takes precedence over any transition the match inputs would cause in that cycle.
- R3: While `state_o` is 00 (not armed), match inputs change neither the state nor the flags.
- R4: In State1 (`state_o`=01) and State2 (`state_o`=10), the code for that state (`s1_code` or `s2_code`) selects one channel with bits [1:0]. Bits [3:2] give that channel's destination: 00 goes to State2, 01 goes to State3, 10 goes to Final, and 11 means no transition. Matches on other channels are ignored.
- R5: In State3 (`state_o`=11), `s3_code` routes matches as follows:
  - 0010: any channel goes to Final.
  - 0011: ch0 goes to State1.
  - 0100: ch0 goes to State2.
  - 0101: ch0 goes to Final, ch1 goes to State1.
  - 0110: ch1 goes to State1.
  - 0111: ch1 goes to State2.
  - 1000: ch1 goes to Final.
  - 1001: ch0 goes to Final, ch2 goes to State2.
  - 1010: ch1 goes to State1, ch3 goes to State2.
  - 1011: ch1 goes to Final, ch3 goes to State2.
  - 1100: ch2 goes to Final.
  - 1101: ch3 goes to Final.
- R6: In State3, codes 0000, 0001, 1110 and 1111 cause no transition, and a match on a channel the current code does not name leaves the state unchanged.
- R7: When several routed matches arrive in one cycle, a route to Final wins. Otherwise the route of the lowest-numbered matching channel wins.
- R8: A transition to Final raises `trig_o` for exactly one cycle, starting the cycle after the deciding match. In that same cycle `state_o` reads 00 and `armed_o` is low.
- R9: While armed, a match on channel i sets flag i. The flag stays set through the rest of the session and after it ends. Writes through `reg_wr`/`reg_wdata` never change any flag.
- R10: With `bank_sel` = 11, `rd_data` is {4'b0000, flag3..flag0} with flag i in bit i. With any other `bank_sel` value, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_wr | input | 1 | Arm strobe: clear flags and start a session |
| reg_wr | input | 1 | Software write strobe to the flag register (ignored) |
| reg_wdata | input | 8 | Software write data (ignored) |
| match_i | input | 4 | Comparator match pulses, bit i = channel i |
| s1_code | input | 4 | State1 route code |
| s2_code | input | 4 | State2 route code |
| s3_code | input | 4 | State3 route code |
| bank_sel | input | 2 | Register bank select for the read port |
| rd_data | output | 8 | Flag register read data |
| state_o | output | 2 | Current state: 00 idle, 01 State1, 10 State2, 11 State3 |
| armed_o | output | 1 | Session active |
| trig_o | output | 1 | One-cycle trigger pulse on entering Final |

## Verification
A wrong State3 decode or a wrong priority choice shows up on `state_o` one cycle after the match that exposed it. If the fault sends the block to Final, a misplaced `trig_o` pulse appears in that same cycle. A flag that was dropped, or set by a match while idle, is not seen until software reads with bank select 11. That read is combinational, so the bench compares the flags in every cycle it drives.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int N_CH   = 4;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_S1   = 2'b01,
    ST_S2   = 2'b10,
    ST_S3   = 2'b11
  } st_e;

  typedef enum logic [2:0] {
    D_NONE = 3'd0,
    D_S1   = 3'd1,
    D_S2   = 3'd2,
    D_S3   = 3'd3,
    D_FIN  = 3'd4
  } dest_e;
endpackage

// File: rtl/dbg_s12_route.sv
module dbg_s12_route
  import dbg_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [N_CH-1:0]   match,
  output dest_e             dest
);
  localparam int SEL_W = $clog2(N_CH);

  logic [SEL_W-1:0] ch;
  logic             hit;

  assign ch  = code[SEL_W-1:0];
  assign hit = match[ch];

  always_comb begin
    dest = D_NONE;
    if (hit) begin
      case (code[CODE_W-1:SEL_W])
        2'b00:   dest = D_S2;
        2'b01:   dest = D_S3;
        2'b10:   dest = D_FIN;
        default: dest = D_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_s3_route.sv
module dbg_s3_route
  import dbg_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [N_CH-1:0]   match,
  output dest_e             dest
);
  function automatic dest_e chan_dest(input logic [CODE_W-1:0] c, input int k);
    dest_e d;
    d = D_NONE;
    case (c)
      4'b0010: d = D_FIN;
      4'b0011: if (k == 0) d = D_S1;
      4'b0100: if (k == 0) d = D_S2;
      4'b0101: if (k == 0) d = D_FIN; else if (k == 1) d = D_S1;
      4'b0110: if (k == 1) d = D_S1;
      4'b0111: if (k == 1) d = D_S2;
      4'b1000: if (k == 1) d = D_FIN;
      4'b1001: if (k == 0) d = D_FIN; else if (k == 2) d = D_S2;
      4'b1010: if (k == 1) d = D_S1;  else if (k == 3) d = D_S2;
      4'b1011: if (k == 1) d = D_FIN; else if (k == 3) d = D_S2;
      4'b1100: if (k == 2) d = D_FIN;
      4'b1101: if (k == 3) d = D_FIN;
      default: d = D_NONE;
    endcase
    return d;
  endfunction

  dest_e           ch_dest [N_CH];
  logic [N_CH-1:0] fin_hit;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_dest[g] = chan_dest(code, g);
    assign fin_hit[g] = match[g] && (ch_dest[g] == D_FIN);
  end

  always_comb begin
    dest = D_NONE;
    if (|fin_hit) begin
      dest = D_FIN;
    end else begin
      for (int i = N_CH - 1; i >= 0; i--) begin
        if (match[i] && ch_dest[i] != D_NONE) dest = ch_dest[i];
      end
    end
  end
endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank
  import dbg_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            set_en,
  input  logic [N_CH-1:0] match,
  input  logic [1:0]      bank_sel,
  output logic [N_CH-1:0] flags,
  output logic [7:0]      rd_data
);
  logic [N_CH-1:0] flags_d;
  logic            flags_en;

  assign flags_en = clr || set_en;

  always_comb begin
    flags_d = flags;
    if (clr)         flags_d = '0;
    else if (set_en) flags_d = flags | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end

  always_comb begin
    rd_data = 8'h00;
    if (bank_sel == 2'b11) rd_data[N_CH-1:0] = flags;
  end

  // R9: set flags are never lost except by arming
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  // R3: no flag change when neither armed nor arming
  a_r3_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set_en) |=> $stable(flags));
  // R10: upper read bits stay zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:N_CH] == '0);
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic [N_CH-1:0]   match_i,
  input  logic [CODE_W-1:0] s1_code,
  input  logic [CODE_W-1:0] s2_code,
  input  logic [CODE_W-1:0] s3_code,
  input  logic [1:0]        bank_sel,
  output logic [7:0]        rd_data,
  output logic [1:0]        state_o,
  output logic              armed_o,
  output logic              trig_o
);
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  st_e               state_q, state_d;
  logic              trig_q, trig_d;
  logic [CODE_W-1:0] s12_code;
  dest_e             d12, d3, dest;
  logic [N_CH-1:0]   flags;
  logic              armed;

  assign armed    = (state_q != ST_IDLE);
  assign s12_code = (state_q == ST_S2) ? s2_code : s1_code;

  dbg_s12_route u_s12 (.code(s12_code), .match(match_i), .dest(d12));
  dbg_s3_route  u_s3  (.code(s3_code),  .match(match_i), .dest(d3));

  always_comb begin
    case (state_q)
      ST_S1, ST_S2: dest = d12;
      ST_S3:        dest = d3;
      default:      dest = D_NONE;
    endcase
  end

  always_comb begin
    state_d = state_q;
    trig_d  = 1'b0;
    if (arm_wr) begin
      state_d = ST_S1;
    end else if (armed) begin
      case (dest)
        D_S1:    state_d = ST_S1;
        D_S2:    state_d = ST_S2;
        D_S3:    state_d = ST_S3;
        D_FIN: begin
          state_d = ST_IDLE;
          trig_d  = 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_d;
    end
  end

  dbg_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (arm_wr),
    .set_en  (armed),
    .match   (match_i),
    .bank_sel(bank_sel),
    .flags   (flags),
    .rd_data (rd_data)
  );

  assign state_o = state_q;
  assign armed_o = armed;
  assign trig_o  = trig_q;

  // R2: arming restarts in State1 with cleared flags and no trigger
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_s_n)
    arm_wr |=> (state_q == ST_S1 && flags == '0 && !trig_q));
  // R3: idle block stays idle without an arm
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE && !arm_wr) |=> (state_q == ST_IDLE && !trig_q));
  // R6: reserved State3 codes hold the state
  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_S3 && !arm_wr && s3_code[3:1] == 3'b111) |=> (state_q == ST_S3));
  // R7: a Final route beats a lower-priority route in the same cycle
  a_r7_final_first: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_S3 && !arm_wr && s3_code == 4'b1011 && match_i[1] && match_i[3])
    |=> trig_q);
  // R8: trigger coincides with idle and lasts one cycle
  a_r8_trig_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    trig_q |-> (state_q == ST_IDLE));
  a_r8_trig_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    trig_q |=> !trig_q);
  // R9: software writes never alter the flags
  a_r9_wr_ignored: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && reg_wdata != 8'h00 && !arm_wr && match_i == '0) |=> $stable(flags));
endmodule

// File: tb/sim_dbg_seq_top.sv
`timescale 1ns/1ps
module sim_dbg_seq_top;
  localparam logic [1:0] S_IDLE = 2'b00, S_S1 = 2'b01, S_S2 = 2'b10, S_S3 = 2'b11;
  localparam logic [2:0] X_NONE = 3'd0, X_S1 = 3'd1, X_S2 = 3'd2, X_S3 = 3'd3, X_FIN = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arm_wr, reg_wr;
  logic [7:0] reg_wdata;
  logic [3:0] match_i, s1_code, s2_code, s3_code;
  logic [1:0] bank_sel;
  logic [7:0] rd_data;
  logic [1:0] state_o;
  logic       armed_o, trig_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0] m_state;
  logic       m_trig;
  logic [3:0] m_flags;

  always #2.5 clk = ~clk;

  dbg_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .match_i(match_i), .s1_code(s1_code), .s2_code(s2_code), .s3_code(s3_code),
    .bank_sel(bank_sel), .rd_data(rd_data), .state_o(state_o), .armed_o(armed_o),
    .trig_o(trig_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_s12(input logic [3:0] c, input logic [3:0] m);
    if (!m[c[1:0]]) return X_NONE;
    if (c[3:2] == 2'b00) return X_S2;
    if (c[3:2] == 2'b01) return X_S3;
    if (c[3:2] == 2'b10) return X_FIN;
    return X_NONE;
  endfunction

  function automatic logic [2:0] exp_s3(input logic [3:0] c, input logic [3:0] m);
    case (c)
      4'b0010: return (m != 0) ? X_FIN : X_NONE;
      4'b0011: return m[0] ? X_S1 : X_NONE;
      4'b0100: return m[0] ? X_S2 : X_NONE;
      4'b0101: begin if (m[0]) return X_FIN; if (m[1]) return X_S1; return X_NONE; end
      4'b0110: return m[1] ? X_S1 : X_NONE;
      4'b0111: return m[1] ? X_S2 : X_NONE;
      4'b1000: return m[1] ? X_FIN : X_NONE;
      4'b1001: begin if (m[0]) return X_FIN; if (m[2]) return X_S2; return X_NONE; end
      4'b1010: begin if (m[1]) return X_S1; if (m[3]) return X_S2; return X_NONE; end
      4'b1011: begin if (m[1]) return X_FIN; if (m[3]) return X_S2; return X_NONE; end
      4'b1100: return m[2] ? X_FIN : X_NONE;
      4'b1101: return m[3] ? X_FIN : X_NONE;
      default: return X_NONE;
    endcase
  endfunction

  // one cycle: drive at negedge, check read port, advance model, check at next negedge
  task automatic step(input logic a, input logic [3:0] m, input logic [3:0] c1,
                      input logic [3:0] c2, input logic [3:0] c3, input logic [1:0] bs,
                      input logic wr, input logic [7:0] wd, input string tag);
    logic [2:0] d;
    arm_wr = a; match_i = m; s1_code = c1; s2_code = c2; s3_code = c3;
    bank_sel = bs; reg_wr = wr; reg_wdata = wd;
    #1;
    chk("R10 read", {24'h0, rd_data}, (bs == 2'b11) ? {28'h0, m_flags} : 32'h0);
    d = X_NONE;
    if (m_state == S_S1) d = exp_s12(c1, m);
    if (m_state == S_S2) d = exp_s12(c2, m);
    if (m_state == S_S3) d = exp_s3(c3, m);
    if (a) begin
      m_flags = 4'h0; m_state = S_S1; m_trig = 1'b0;
    end else if (m_state != S_IDLE) begin
      m_flags = m_flags | m;
      m_trig  = (d == X_FIN);
      case (d)
        X_S1: m_state = S_S1;
        X_S2: m_state = S_S2;
        X_S3: m_state = S_S3;
        X_FIN: m_state = S_IDLE;
        default: ;
      endcase
    end else begin
      m_trig = 1'b0;
    end
    @(negedge clk);
    chk({tag, " state"}, {30'h0, state_o}, {30'h0, m_state});
    chk({tag, " trig"},  {31'h0, trig_o},  {31'h0, m_trig});
    chk({tag, " armed"}, {31'h0, armed_o}, {31'h0, (m_state != S_IDLE)});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; arm_wr = 0; reg_wr = 0; reg_wdata = 0; match_i = 0;
    s1_code = 0; s2_code = 0; s3_code = 0; bank_sel = 2'b11;
    m_state = S_IDLE; m_trig = 0; m_flags = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {30'h0, state_o}, 32'h0);
    chk("R1 reset trig", {31'h0, trig_o}, 32'h0);
    chk("R1 reset rd", {24'h0, rd_data}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release armed", {31'h0, armed_o}, 32'h0);

    step(0, 4'hF, 4'h0, 4'h0, 4'h0, 2'b11, 0, 8'h0, "R3 idle match");
    step(1, 4'h0, 4'b0100, 4'h0, 4'h0, 2'b11, 0, 8'h0, "R2 arm");
    step(0, 4'b0010, 4'b0100, 4'h0, 4'h0, 2'b11, 0, 8'h0, "R4 other channel");
    step(0, 4'b0001, 4'b0100, 4'h0, 4'b1110, 2'b11, 0, 8'h0, "R4 to State3");
    step(0, 4'hF, 4'b0100, 4'h0, 4'b1110, 2'b11, 0, 8'h0, "R6 reserved 1110");
    step(0, 4'hF, 4'b0100, 4'h0, 4'b0000, 2'b11, 0, 8'h0, "R6 code 0000");
    step(0, 4'b0101, 4'b0100, 4'h0, 4'b0110, 2'b11, 0, 8'h0, "R6 unnamed channels");
    step(0, 4'b1010, 4'b0110, 4'h0, 4'b1010, 2'b11, 0, 8'h0, "R7 lower channel wins");
    step(0, 4'b0100, 4'b0110, 4'h0, 4'b1010, 2'b11, 0, 8'h0, "R4 State1 ch2");
    step(0, 4'b0101, 4'b0110, 4'h0, 4'b1001, 2'b11, 0, 8'h0, "R7 Final first R8");
    step(0, 4'hF, 4'h0, 4'h0, 4'b0010, 2'b11, 0, 8'h0, "R8 pulse ends R3");
    step(0, 4'h0, 4'h0, 4'h0, 4'h0, 2'b11, 1, 8'hF0, "R9 write ignored");
    step(0, 4'h0, 4'h0, 4'h0, 4'h0, 2'b10, 1, 8'h00, "R10 bank 10");
    step(1, 4'h0, 4'b0000, 4'b0101, 4'h0, 2'b11, 0, 8'h0, "R2 rearm clears");
    step(0, 4'b0001, 4'b0000, 4'b0101, 4'h0, 2'b11, 0, 8'h0, "R4 to State2");
    step(0, 4'b0010, 4'b0000, 4'b0101, 4'b0010, 2'b11, 0, 8'h0, "R4 State2 to State3");
    step(1, 4'b1000, 4'h0, 4'h0, 4'b1101, 2'b11, 0, 8'h0, "R2 arm beats Final");
    step(0, 4'b0000, 4'b1000, 4'h0, 4'h0, 2'b11, 0, 8'h0, "R4 hold");
    step(0, 4'b0001, 4'b1000, 4'h0, 4'h0, 2'b11, 0, 8'h0, "R8 State1 to Final");

    for (int i = 0; i < 4000; i++) begin
      logic a;
      logic [3:0] m;
      a = ($urandom % 32) == 0;
      m = 4'($urandom) & 4'($urandom);
      step(a, m, 4'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
           1'($urandom), 8'($urandom), "R5 random R7");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule